// File: doc/BRIEF.md
# Video Decoder Host Register Port with Indirect Indexing

This block is the 8-bit parallel host port of a video decoder. Most of the decoder's control registers sit behind a two-step scheme: the host first stores a register index through an index port, then reads or writes a data port that reaches whichever register the index selects. Two further direct host addresses skip that step. One drains the teletext FIFO a byte at a time. The other shows the interrupt status register.

The status register gathers eight flags: a live lock level, a latched lock-change event, cycle-complete and bus-error events, live indications that the odd-field or even-field closed-caption buffer is non-empty, a teletext threshold flag and a teletext data-ready flag. The data-ready flag is qualified by a match between the current video line and a programmed line number. Latched flags clear only when the host writes a 1 to them. An interrupt line goes high when a latched flag is set and that flag is enabled. The slicers and the FIFO storage are outside the block. They reach it only as level and pulse inputs, plus a show-ahead FIFO read port.

Top module: `vdec_host_regs`

## Requirements
- R1: A host write to address 0x00 stores the register index, and a read of 0x00 returns it. Reads and writes at 0x01 reach the register selected by the index. An index that selects no register reads 0x00 and ignores writes. Read data appears on `host_rdata` in the cycle after the read strobe and holds until the next read.
- R2: A read at address 0x10, or at 0x01 with index 0xB0, returns the byte at the head of the teletext FIFO and pulses `ttx_pop` for exactly one cycle. If the FIFO is empty, the read returns 0x00 and `ttx_pop` stays low.
- R3: A read of address 0x11 and a read of 0x01 with index 0xC0 return the same status byte. A write through either path clears the same bits.
- R4: The status byte has these bits: bit 7 lock level, bit 6 lock changed, bit 5 cycle complete, bit 4 bus error, bit 3 odd-field caption non-empty, bit 2 even-field caption non-empty, bit 1 teletext threshold, bit 0 teletext data ready. After reset every latched bit is 0.
- R5: A latched bit (6, 5, 4, 1 or 0), once set, stays set until the host writes that status byte with a 1 in its position. Writing 0 leaves it unchanged.
- R6: Bit 0 sets when `line_num` equals the programmed interrupt line and `ttx_complete` is high. If bit 0 of the mode register (index 0xC5) is 1, the line match alone sets it. The line is programmed at index 0xC2 (bits 7:0) and 0xC3 (the upper bits).
- R7: Bit 1 sets when the threshold at index 0xC4 is non-zero and `ttx_count` is greater than or equal to it. A threshold of 0 disables the flag.
- R8: Bits 3 and 2 follow `cc_odd` and `cc_even` directly. Writing 1 to them has no effect.
- R9: Bit 7 is the live `lock_in` level at the time of the read. Bit 6 latches on any change of `lock_in`.
- R10: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: `irq` is high when some latched status bit is set and the matching bit of the enable register (index 0xC1) is 1. The live bits 7, 3 and 2 never drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| ttx_data | input | 8 | Head byte of teletext FIFO (show-ahead) |
| ttx_empty | input | 1 | Teletext FIFO empty |
| ttx_pop | output | 1 | Teletext FIFO pop strobe |
| ttx_count | input | CNT_W | Teletext bytes buffered |
| ttx_complete | input | 1 | Buffer holds a complete transaction |
| line_num | input | LINE_W | Current video line |
| lock_in | input | 1 | Decoder lock level |
| cc_odd | input | 1 | Odd-field caption buffer non-empty |
| cc_even | input | 1 | Even-field caption buffer non-empty |
| bus_err | input | 1 | Bus error event pulse |
| cyc_done | input | 1 | Cycle complete event pulse |

## Verification
The bench uses the defaults LINE_W = 10 and CNT_W = 8. The 10-bit line width puts part of the line compare in the upper-byte register at index 0xC3. A line that matches only in its low byte must therefore not set the data-ready flag. The 8-bit count lets the bench step `ttx_count` across a threshold of 10, one value on each side. Randomly timed event pulses are mixed with random clear masks, some of them in the same cycle as an event, so the set-wins rule and the clear rule are checked together.

// File: rtl/vdh_pkg.sv
package vdh_pkg;

    localparam int HOST_W = 8;

    localparam logic [7:0] A_INDEX  = 8'h00;
    localparam logic [7:0] A_DATA   = 8'h01;
    localparam logic [7:0] A_TTX    = 8'h10;
    localparam logic [7:0] A_STATUS = 8'h11;

    localparam logic [7:0] X_TTX     = 8'hB0;
    localparam logic [7:0] X_STATUS  = 8'hC0;
    localparam logic [7:0] X_IEN     = 8'hC1;
    localparam logic [7:0] X_LINE_LO = 8'hC2;
    localparam logic [7:0] X_LINE_HI = 8'hC3;
    localparam logic [7:0] X_THRESH  = 8'hC4;
    localparam logic [7:0] X_MODE    = 8'hC5;

    localparam int B_TTX_DATA = 0;
    localparam int B_TTX_THR  = 1;
    localparam int B_CC_EVEN  = 2;
    localparam int B_CC_ODD   = 3;
    localparam int B_BUS_ERR  = 4;
    localparam int B_CYC_DONE = 5;
    localparam int B_LOCK_CHG = 6;
    localparam int B_LOCK     = 7;

    localparam logic [7:0] LATCH_MASK = 8'b0111_0011;

    typedef enum logic [3:0] {
        TG_NONE, TG_INDEX, TG_TTX, TG_STATUS, TG_IEN,
        TG_LINE_LO, TG_LINE_HI, TG_THRESH, TG_MODE
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    rd;
        logic    wr;
    } access_t;

    function automatic target_e index_target(input logic [7:0] idx);
        case (idx)
            X_TTX:     return TG_TTX;
            X_STATUS:  return TG_STATUS;
            X_IEN:     return TG_IEN;
            X_LINE_LO: return TG_LINE_LO;
            X_LINE_HI: return TG_LINE_HI;
            X_THRESH:  return TG_THRESH;
            X_MODE:    return TG_MODE;
            default:   return TG_NONE;
        endcase
    endfunction

    function automatic logic [7:0] w1c_next(input logic [7:0] cur,
                                            input logic [7:0] clr,
                                            input logic [7:0] set);
        return ((cur & ~clr) | set) & LATCH_MASK;
    endfunction

endpackage

// File: rtl/vdh_decode.sv
module vdh_decode
    import vdh_pkg::*;
(
    input  logic [HOST_W-1:0] addr,
    input  logic [7:0]        index,
    input  logic              rd,
    input  logic              wr,
    output access_t           acc
);
    always_comb begin
        acc.rd = rd;
        acc.wr = wr;
        case (addr)
            A_INDEX:  acc.tgt = TG_INDEX;
            A_DATA:   acc.tgt = index_target(index);
            A_TTX:    acc.tgt = TG_TTX;
            A_STATUS: acc.tgt = TG_STATUS;
            default:  acc.tgt = TG_NONE;
        endcase
    end
endmodule

// File: rtl/vdh_cfg_regs.sv
module vdh_cfg_regs
    import vdh_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [HOST_W-1:0] wdata,
    output logic [7:0]        index_q,
    output logic [7:0]        ien_q,
    output logic [LINE_W-1:0] line_q,
    output logic [CNT_W-1:0]  thresh_q,
    output logic              line_only_q
);
    localparam int HI_W = LINE_W - 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q     <= '0;
            ien_q       <= '0;
            line_q      <= '0;
            thresh_q    <= '0;
            line_only_q <= 1'b0;
        end else if (acc.wr) begin
            case (acc.tgt)
                TG_INDEX:   index_q           <= wdata;
                TG_IEN:     ien_q             <= wdata;
                TG_LINE_LO: line_q[7:0]       <= wdata;
                TG_LINE_HI: line_q[LINE_W-1:8] <= wdata[HI_W-1:0];
                TG_THRESH:  thresh_q          <= wdata[CNT_W-1:0];
                TG_MODE:    line_only_q       <= wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vdh_status.sv
module vdh_status
    import vdh_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_i,
    input  logic              cc_odd_i,
    input  logic              cc_even_i,
    input  logic              ttx_complete_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              bus_err_i,
    input  logic              cyc_done_i,
    input  logic [LINE_W-1:0] irq_line_i,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic              line_only_i,
    input  logic [7:0]        clr_i,
    output logic [7:0]        status_o,
    output logic [7:0]        lat_o
);
    logic       lock_q;
    logic [7:0] lat_q;
    logic [7:0] set_v;
    logic       line_hit;

    assign line_hit = (line_i == irq_line_i);

    always_comb begin
        set_v              = '0;
        set_v[B_TTX_DATA]  = line_hit && (ttx_complete_i || line_only_i);
        set_v[B_TTX_THR]   = (thresh_i != '0) && (count_i >= thresh_i);
        set_v[B_BUS_ERR]   = bus_err_i;
        set_v[B_CYC_DONE]  = cyc_done_i;
        set_v[B_LOCK_CHG]  = (lock_i != lock_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            lock_q <= lock_i;
        end else begin
            lat_q  <= w1c_next(lat_q, clr_i, set_v);
            lock_q <= lock_i;
        end
    end

    always_comb begin
        status_o            = lat_q;
        status_o[B_LOCK]    = lock_i;
        status_o[B_CC_ODD]  = cc_odd_i;
        status_o[B_CC_EVEN] = cc_even_i;
    end

    assign lat_o = lat_q;
endmodule

// File: rtl/vdec_host_regs.sv
module vdec_host_regs
    import vdh_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic              irq,
    input  logic [7:0]        ttx_data,
    input  logic              ttx_empty,
    output logic              ttx_pop,
    input  logic [CNT_W-1:0]  ttx_count,
    input  logic              ttx_complete,
    input  logic [LINE_W-1:0] line_num,
    input  logic              lock_in,
    input  logic              cc_odd,
    input  logic              cc_even,
    input  logic              bus_err,
    input  logic              cyc_done
);
    access_t           acc;
    logic [7:0]        index_q;
    logic [7:0]        ien_q;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  thresh_q;
    logic              line_only_q;
    logic [7:0]        clr_mask;
    logic [7:0]        status_v;
    logic [7:0]        lat_q;
    logic [7:0]        rd_mux;
    logic [7:0]        rdata_q;

    vdh_decode u_dec (
        .addr  (host_addr),
        .index (index_q),
        .rd    (host_rd),
        .wr    (host_wr),
        .acc   (acc)
    );

    vdh_cfg_regs #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .wdata       (host_wdata),
        .index_q     (index_q),
        .ien_q       (ien_q),
        .line_q      (line_q),
        .thresh_q    (thresh_q),
        .line_only_q (line_only_q)
    );

    assign clr_mask = (acc.wr && acc.tgt == TG_STATUS) ? host_wdata : 8'h00;

    vdh_status #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_st (
        .clk            (clk),
        .rst            (rst),
        .lock_i         (lock_in),
        .cc_odd_i       (cc_odd),
        .cc_even_i      (cc_even),
        .ttx_complete_i (ttx_complete),
        .line_i         (line_num),
        .count_i        (ttx_count),
        .bus_err_i      (bus_err),
        .cyc_done_i     (cyc_done),
        .irq_line_i     (line_q),
        .thresh_i       (thresh_q),
        .line_only_i    (line_only_q),
        .clr_i          (clr_mask),
        .status_o       (status_v),
        .lat_o          (lat_q)
    );

    assign ttx_pop = acc.rd && (acc.tgt == TG_TTX) && !ttx_empty;

    always_comb begin
        rd_mux = 8'h00;
        case (acc.tgt)
            TG_INDEX:   rd_mux = index_q;
            TG_TTX:     rd_mux = ttx_empty ? 8'h00 : ttx_data;
            TG_STATUS:  rd_mux = status_v;
            TG_IEN:     rd_mux = ien_q;
            TG_LINE_LO: rd_mux = line_q[7:0];
            TG_LINE_HI: rd_mux[LINE_W-9:0] = line_q[LINE_W-1:8];
            TG_THRESH:  rd_mux[CNT_W-1:0] = thresh_q;
            TG_MODE:    rd_mux[0] = line_only_q;
            default:    rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (host_rd) rdata_q <= rd_mux;
    end

    assign host_rdata = rdata_q;
    assign irq        = |(lat_q & ien_q & LATCH_MASK);
endmodule

// File: rtl/vdec_host_regs_chk.sv
module vdec_host_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_rd,
    input logic [7:0] host_addr,
    input logic [7:0] host_rdata,
    input logic       ttx_pop,
    input logic       ttx_empty,
    input logic       lock_in,
    input logic       bus_err,
    input logic       irq,
    input logic [7:0] lat,
    input logic [7:0] ien,
    input logic [7:0] clr
);
    p_pop_guard_r2: assert property (@(posedge clk) disable iff (rst)
        ttx_pop |-> (host_rd && !ttx_empty));

    p_empty_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 8'h10 && ttx_empty) |=> (host_rdata == 8'h00));

    p_reset_clear_r4: assert property (@(posedge clk)
        rst |=> (lat == 8'h00));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (lat[4] && !clr[4]) |=> lat[4]);

    p_lock_live_r9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == 8'h11) |=> (host_rdata[7] == $past(lock_in)));

    p_lock_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (lock_in != $past(lock_in)) |=> lat[6]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> lat[4]);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        ((lat & ien) == 8'h00) |-> !irq);
endmodule

bind vdec_host_regs vdec_host_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .ttx_pop    (ttx_pop),
    .ttx_empty  (ttx_empty),
    .lock_in    (lock_in),
    .bus_err    (bus_err),
    .irq        (irq),
    .lat        (lat_q),
    .ien        (ien_q),
    .clr        (clr_mask)
);

// File: tb/vdec_host_regs_test.sv
`timescale 1ns/1ps
module vdec_host_regs_test;
    localparam int LINE_W = 10;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic host_wr = 1'b0, host_rd = 1'b0, irq;
    logic [7:0] ttx_data;
    logic ttx_empty, ttx_pop;
    logic [CNT_W-1:0] ttx_count = '0;
    logic ttx_complete = 1'b0;
    logic [LINE_W-1:0] line_num = 10'd100;
    logic lock_in = 1'b0, cc_odd = 1'b0, cc_even = 1'b0;
    logic bus_err = 1'b0, cyc_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] fmem [0:15];
    int fwp = 0;
    int frp = 0;
    int pops = 0;

    assign ttx_data  = fmem[frp[3:0]];
    assign ttx_empty = (fwp == frp);

    always #5 clk = ~clk;

    always @(posedge clk) if (ttx_pop) begin frp <= frp + 1; pops <= pops + 1; end

    vdec_host_regs #(.LINE_W(LINE_W), .CNT_W(CNT_W)) uut (.*);

    function automatic logic [7:0] st_exp(input logic lk, lc, cd, be, co, ce, th, td);
        return {lk, lc, cd, be, co, ce, th, td};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic iw(input logic [7:0] idx, input logic [7:0] d);
        hw(8'h00, idx);
        hw(8'h01, d);
    endtask

    task automatic push(input logic [7:0] d);
        fmem[fwp[3:0]] = d;
        fwp++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2, m, mask;
        int p0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4 reset state
        hr(8'h11, v); chk("R4 reset status", v, 8'h00);
        chk("R11 reset irq", {7'b0, irq}, 8'h00);
        hr(8'h00, v); chk("R1 reset index", v, 8'h00);

        // R1 indirect access
        hw(8'h00, 8'hC4);
        hr(8'h00, v); chk("R1 index readback", v, 8'hC4);
        hw(8'h01, 8'h5A);
        hr(8'h01, v); chk("R1 indirect readback", v, 8'h5A);
        hw(8'h00, 8'h37);
        hw(8'h01, 8'hFF);
        hr(8'h01, v); chk("R1 unmapped index", v, 8'h00);
        iw(8'hC4, 8'h00);

        // R2 teletext FIFO port
        push(8'hA1); push(8'hB2); push(8'hC3);
        p0 = pops;
        hr(8'h10, v); chk("R2 direct head", v, 8'hA1);
        chk("R2 one pop", 8'(pops - p0), 8'd1);
        hw(8'h00, 8'hB0);
        hr(8'h01, v); chk("R2 indirect head", v, 8'hB2);
        hr(8'h10, v); chk("R2 third byte", v, 8'hC3);
        chk("R2 pops total", 8'(pops - p0), 8'd3);
        hr(8'h10, v); chk("R2 empty read", v, 8'h00);
        chk("R2 no underflow pop", 8'(pops - p0), 8'd3);

        // R9 lock
        @(negedge clk); lock_in = 1'b1;
        hr(8'h11, v); chk("R9 lock rise", v, st_exp(1,1,0,0,0,0,0,0));
        hw(8'h11, 8'h40);
        hr(8'h11, v); chk("R9 lock chg cleared", v, st_exp(1,0,0,0,0,0,0,0));
        @(negedge clk); lock_in = 1'b0;
        hr(8'h11, v); chk("R9 lock fall", v, st_exp(0,1,0,0,0,0,0,0));
        hw(8'h11, 8'h40);

        // R5 / R3 write-1-to-clear and mirror
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        hw(8'h11, 8'hEF);
        hr(8'h11, v); chk("R5 write0 keeps", v, st_exp(0,0,0,1,0,0,0,0));
        hw(8'h00, 8'hC0);
        hr(8'h01, v2); chk("R3 mirror equal", v2, v);
        hw(8'h01, 8'h10);
        hr(8'h11, v); chk("R3 clear via index", v, 8'h00);

        // R10 set wins
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); host_addr = 8'h11; host_wdata = 8'h10; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0; bus_err = 1'b0;
        hr(8'h11, v); chk("R10 set beats clear", v, st_exp(0,0,0,1,0,0,0,0));
        hw(8'h11, 8'h10);

        // R8 caption live bits
        @(negedge clk); cc_odd = 1'b1;
        hw(8'h11, 8'h0C);
        hr(8'h11, v); chk("R8 odd live", v, st_exp(0,0,0,0,1,0,0,0));
        @(negedge clk); cc_odd = 1'b0; cc_even = 1'b1;
        hr(8'h11, v); chk("R8 even live", v, st_exp(0,0,0,0,0,1,0,0));
        @(negedge clk); cc_even = 1'b0;
        hr(8'h11, v); chk("R8 empty", v, 8'h00);

        // R6 teletext data with line match
        iw(8'hC2, 8'h23); iw(8'hC3, 8'h01);
        @(negedge clk); line_num = 10'h123;
        @(negedge clk); line_num = 10'd100;
        hr(8'h11, v); chk("R6 match no data", v, 8'h00);
        @(negedge clk); line_num = 10'h023; ttx_complete = 1'b1;
        @(negedge clk); line_num = 10'h123;
        @(negedge clk); line_num = 10'd100; ttx_complete = 1'b0;
        hr(8'h11, v); chk("R6 match with data", v, st_exp(0,0,0,0,0,0,0,1));
        hw(8'h11, 8'h01);
        hr(8'h11, v); chk("R6 cleared, low-byte match ignored", v, 8'h00);
        iw(8'hC5, 8'h01);
        @(negedge clk); line_num = 10'h123;
        @(negedge clk); line_num = 10'd100;
        hr(8'h11, v); chk("R6 line-only mode", v, st_exp(0,0,0,0,0,0,0,1));
        hw(8'h11, 8'h01);
        iw(8'hC5, 8'h00);

        // R7 threshold
        iw(8'hC4, 8'd10);
        @(negedge clk); ttx_count = 8'd9;
        hr(8'h11, v); chk("R7 below threshold", v, 8'h00);
        @(negedge clk); ttx_count = 8'd10;
        @(negedge clk); ttx_count = 8'd0;
        hr(8'h11, v); chk("R7 reached threshold", v, st_exp(0,0,0,0,0,0,1,0));
        hw(8'h11, 8'h02);
        hr(8'h11, v); chk("R7 cleared", v, 8'h00);

        // R11 interrupt enable
        @(negedge clk); cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
        chk("R11 disabled", {7'b0, irq}, 8'h00);
        iw(8'hC1, 8'h20);
        @(negedge clk); chk("R11 enabled", {7'b0, irq}, 8'h01);
        hw(8'h11, 8'h20);
        @(negedge clk); cc_odd = 1'b1;
        iw(8'hC1, 8'h08);
        @(negedge clk); chk("R11 live bit no irq", {7'b0, irq}, 8'h00);
        cc_odd = 1'b0;

        // random events and clears (R5, R10, R11)
        iw(8'hC1, 8'h10);
        hw(8'h11, 8'hFF);
        m = 8'h00;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            mask = 8'($urandom);
            @(negedge clk);
            bus_err = r[0]; cyc_done = r[1];
            if (r[2]) begin host_addr = 8'h11; host_wdata = mask; host_wr = 1'b1; end
            m = ((m & ~(r[2] ? mask : 8'h00)) | {2'b00, r[1], r[0], 4'b0000}) & 8'h30;
            @(negedge clk);
            bus_err = 1'b0; cyc_done = 1'b0; host_wr = 1'b0;
            hr(8'h11, v);
            chk("R5 random status", v, m);
            chk("R11 random irq", {7'b0, irq}, {7'b0, m[4]});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule